// File: doc/BRIEF.md
# Runtime-Configurable Asynchronous Serial Transmitter

This block turns one parallel word into an asynchronous serial frame on a single output line. Each frame has a low start bit, then 5 to 9 data bits sent least significant bit first, then an optional even or odd parity bit, and then one or two high stop bits. The format is chosen per word through plain configuration pins. A programmable divisor sets the bit period as a count of system clocks.

Words enter through a valid/ready stream port. A word is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. At that edge the block samples the word, the format pins and the divisor, and uses them for the whole frame. While a frame is on the line, `in_ready` stays low. This is the only back-pressure: the source must hold its word until `in_ready` returns. While `in_ready` is low, the block ignores `in_valid`, `in_data` and every configuration pin. `busy` is high for exactly as long as a frame is in flight.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `tx` is high, `busy` is low and `in_ready` is high, and the line stays high for as long as no word is offered.
- R2: A word is accepted on an edge where `in_valid` and `in_ready` are both high. `in_ready` is low from that edge until the last stop bit has ended, and is high again in the cycle right after the frame. While `in_ready` is low, changes on `in_valid` and `in_data` do not alter the frame on the line.
- R3: The frame begins with a low start bit. The start bit begins in the cycle after the accepting edge and lasts one bit period.
- R4: The data field is sent least significant bit first. Its length is `cfg_data_bits` when that value lies from 5 to 9. A value below 5 sends 5 bits, and a value above 9 sends 9 bits.
- R5: When `cfg_parity_en` is 1, one parity bit follows the data. With `cfg_parity_odd`=0, the parity bit makes the number of ones across data and parity even. With `cfg_parity_odd`=1, it makes that number odd.
- R6: A request for 9 data bits while parity is enabled sends 8 data bits, followed by the parity bit.
- R7: The frame ends with high stop bits: one stop bit when `cfg_two_stop`=0 and two when `cfg_two_stop`=1.
- R8: Every bit lasts `cfg_div` system clock cycles. A divisor of 0 behaves as 1.
- R9: The format pins and the divisor are sampled only at the accepting edge. Changing them during a frame has no effect on that frame.
- R10: `busy` is high from the accepting edge until the last stop bit ends, and `tx` is high whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Bit period in clock cycles (0 acts as 1) |
| cfg_data_bits | input | 4 | Requested data bit count |
| cfg_parity_en | input | 1 | Adds a parity bit when 1 |
| cfg_parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_two_stop | input | 1 | 1 selects two stop bits, 0 selects one |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The block can accept a word |
| in_data | input | 9 | Word to send; bits above the data length are ignored |
| tx | output | 1 | Serial line, high when idle |
| busy | output | 1 | A frame is in flight |

## Verification
Two things can fall in the same cycle: the tick that ends a bit and a change on the stream or configuration inputs. The bench provokes this by driving `in_valid` together with a new word and a different format and divisor in the first cycles of a frame. It then checks every cycle of the line against a frame it builds from the format that was accepted. A second meeting happens at the frame's end, where the final tick and the return of `in_ready` meet. The bench checks that the line, `busy` and `in_ready` settle in that same cycle, with no new frame started.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int MIN_DATA_BITS = 5;
  localparam int MAX_DATA_BITS = 9;
  localparam int PAR_DATA_BITS = 8;
  localparam int FRAME_MAX     = 1 + MAX_DATA_BITS + 1 + 2;
  localparam int LEN_W         = $clog2(FRAME_MAX + 1);

  typedef struct packed {
    logic [3:0] data_bits;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
  } frame_fmt_t;

  // Clamp a requested data length to what the format allows.
  function automatic logic [3:0] clamp_bits(input logic [3:0] req, input logic par_en);
    logic [3:0] r;
    if (req < 4'(MIN_DATA_BITS))      r = 4'(MIN_DATA_BITS);
    else if (req > 4'(MAX_DATA_BITS)) r = 4'(MAX_DATA_BITS);
    else                              r = req;
    if (par_en && r > 4'(PAR_DATA_BITS)) r = 4'(PAR_DATA_BITS);
    return r;
  endfunction

endpackage

// File: rtl/uart_parity_gen.sv
module uart_parity_gen #(
  parameter int MAX_BITS = 9
) (
  input  logic [MAX_BITS-1:0] data,
  input  logic [3:0]          nbits,
  input  logic                odd,
  output logic                par
);
  logic [MAX_BITS-1:0] masked;

  always_comb begin
    for (int i = 0; i < MAX_BITS; i++) begin
      masked[i] = (i < int'(nbits)) ? data[i] : 1'b0;
    end
    par = (^masked) ^ odd;
  end
endmodule

// File: rtl/uart_frame_pack.sv
module uart_frame_pack
  import uart_tx_pkg::*;
#(
  parameter int MAX_BITS = MAX_DATA_BITS,
  parameter int FRAME_W  = FRAME_MAX,
  parameter int LEN_BW   = LEN_W
) (
  input  logic [MAX_BITS-1:0] data,
  input  frame_fmt_t          fmt,
  input  logic                par,
  output logic [FRAME_W-1:0]  frame,
  output logic [LEN_BW-1:0]   total
);
  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < MAX_BITS; i++) begin
      if (i < int'(fmt.data_bits)) frame[1+i] = data[i];
    end
    if (fmt.par_en) frame[1 + int'(fmt.data_bits)] = par;
    total = LEN_BW'(1) + LEN_BW'(fmt.data_bits) + LEN_BW'(fmt.par_en)
          + (fmt.two_stop ? LEN_BW'(2) : LEN_BW'(1));
  end
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;

  assign last = (divisor == '0) ? '0 : divisor - DIV_W'(1);
  assign tick = run && (cnt_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (run)     cnt_q <= tick ? '0 : cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [3:0]       cfg_data_bits,
  input  logic             cfg_parity_en,
  input  logic             cfg_parity_odd,
  input  logic             cfg_two_stop,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [8:0]       in_data,
  output logic             tx,
  output logic             busy
);
  localparam int FRAME_W = FRAME_MAX;
  localparam int LEN_BW  = LEN_W;

  frame_fmt_t          fmt;
  logic                par;
  logic [FRAME_W-1:0]  frame;
  logic [LEN_BW-1:0]   total;
  logic                accept;
  logic                baud_tick;

  logic                busy_q;
  logic                tx_q;
  logic [FRAME_W-1:0]  shift_q;
  logic [LEN_BW-1:0]   left_q;
  logic [DIV_W-1:0]    div_q;

  always_comb begin
    fmt.par_en    = cfg_parity_en;
    fmt.par_odd   = cfg_parity_odd;
    fmt.two_stop  = cfg_two_stop;
    fmt.data_bits = clamp_bits(cfg_data_bits, cfg_parity_en);
  end

  uart_parity_gen #(.MAX_BITS(MAX_DATA_BITS)) u_par (
    .data (in_data),
    .nbits(fmt.data_bits),
    .odd  (fmt.par_odd),
    .par  (par)
  );

  uart_frame_pack #(.MAX_BITS(MAX_DATA_BITS), .FRAME_W(FRAME_W), .LEN_BW(LEN_BW)) u_pack (
    .data (in_data),
    .fmt  (fmt),
    .par  (par),
    .frame(frame),
    .total(total)
  );

  uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(accept),
    .run    (busy_q),
    .divisor(div_q),
    .tick   (baud_tick)
  );

  assign in_ready = !busy_q;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      tx_q    <= 1'b1;
      shift_q <= '1;
      left_q  <= '0;
      div_q   <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      tx_q    <= 1'b0;
      shift_q <= frame >> 1;
      left_q  <= total - LEN_BW'(1);
      div_q   <= cfg_div;
    end else if (baud_tick) begin
      if (left_q == '0) begin
        busy_q <= 1'b0;
        tx_q   <= 1'b1;
      end else begin
        tx_q    <= shift_q[0];
        shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
        left_q  <= left_q - LEN_BW'(1);
      end
    end
  end

  assign tx   = tx_q;
  assign busy = busy_q;
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx,
  input logic busy,
  input logic in_valid,
  input logic in_ready,
  input logic tick
);
  // R10
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !tx));

  // R8
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(tick)) |-> $stable(tx));

  // R7
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (tx && $past(tx)));

  // R2
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> busy);
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tx      (tx),
  .busy    (busy),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .tick    (baud_tick)
);

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] cfg_div = '0;
  logic [3:0]       cfg_data_bits = 4'd8;
  logic             cfg_parity_en = 1'b0;
  logic             cfg_parity_odd = 1'b0;
  logic             cfg_two_stop = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [8:0]       in_data = '0;
  logic             tx;
  logic             busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_frame_tx #(.DIV_W(DIV_W)) u_uart_frame_tx (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_data_bits(cfg_data_bits),
    .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
    .cfg_two_stop(cfg_two_stop), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .tx(tx), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_bits(input int req, input bit pe);
    int n;
    n = req < 5 ? 5 : (req > 9 ? 9 : req);
    if (pe && n == 9) n = 8;
    return n;
  endfunction

  // Expected line levels of one frame, bit 0 first; returns the bit count.
  function automatic int build(input logic [8:0] d, input int req, input bit pe,
                               input bit po, input bit ts, output logic [15:0] f);
    int n, k, ones;
    n = eff_bits(req, pe);
    f = '1;
    f[0] = 1'b0;
    k = 1;
    ones = 0;
    for (int i = 0; i < n; i++) begin
      f[k] = d[i];
      ones += int'(d[i]);
      k++;
    end
    if (pe) begin
      f[k] = po ? ((ones % 2) == 0) : ((ones % 2) == 1);
      k++;
    end
    k += ts ? 2 : 1;
    return k;
  endfunction

  task automatic send(input logic [8:0] d, input int req, input bit pe, input bit po,
                      input bit ts, input int div, input bit perturb, input string req_tag);
    logic [15:0] f;
    int total, dv, bad_bit, bad_act, bad_exp;
    bit ok;
    total = build(d, req, pe, po, ts, f);
    dv = (div == 0) ? 1 : div;
    @(negedge clk);
    in_data = d; cfg_data_bits = 4'(req); cfg_parity_en = pe;
    cfg_parity_odd = po; cfg_two_stop = ts; cfg_div = DIV_W'(div);
    in_valid = 1'b1;
    @(posedge clk);
    ok = 1; bad_bit = -1; bad_act = 0; bad_exp = 0;
    for (int j = 0; j < total; j++) begin
      for (int c = 0; c < dv; c++) begin
        @(negedge clk);
        if (j == 0 && c == 0) begin
          if (perturb) begin
            // R9: different word, format and divisor offered mid-frame
            in_data = ~d; cfg_data_bits = 4'd5; cfg_parity_en = ~pe;
            cfg_parity_odd = ~po; cfg_two_stop = ~ts; cfg_div = DIV_W'(dv + 3);
            in_valid = 1'b1;
          end else begin
            in_valid = 1'b0;
          end
        end else if (j == 0 && c == 1 || (j == 1 && c == 0)) begin
          in_valid = 1'b0;
        end
        if (ok && (tx !== f[j] || busy !== 1'b1 || in_ready !== 1'b0)) begin
          ok = 0; bad_bit = j; bad_act = {tx, busy, in_ready}; bad_exp = {f[j], 2'b10};
        end
      end
    end
    check(ok, req_tag, $sformatf("frame bit %0d {tx,busy,ready}", bad_bit), bad_act, bad_exp);
    @(negedge clk);
    in_valid = 1'b0;
    // R2 R10: frame over, ready back the following cycle, line idle
    check(tx === 1'b1 && busy === 1'b0 && in_ready === 1'b1, "R2",
          "end {tx,busy,ready}", {tx, busy, in_ready}, 3'b101);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(tx === 1'b1 && busy === 1'b0 && in_ready === 1'b1, "R1",
          "reset {tx,busy,ready}", {tx, busy, in_ready}, 3'b101);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(tx === 1'b1 && busy === 1'b0, "R1", "idle {tx,busy}", {tx, busy}, 2'b10);

    // directed corner cases
    send(9'h0A5, 8, 0, 0, 0, 4, 0, "R4");       // plain 8N1
    send(9'h1A5, 9, 0, 0, 1, 3, 0, "R4");       // 9 data bits, two stops R7
    send(9'h0FF, 8, 1, 0, 0, 2, 0, "R5");       // even parity, eight ones
    send(9'h000, 8, 1, 1, 0, 2, 0, "R5");       // odd parity, no ones
    send(9'h1FF, 9, 1, 0, 1, 2, 0, "R6");       // 9 with parity clamps to 8
    send(9'h01F, 2, 0, 0, 0, 2, 0, "R4");       // below 5 sends 5
    send(9'h155, 15, 0, 1, 0, 2, 0, "R4");      // above 9 sends 9
    send(9'h033, 7, 1, 1, 1, 0, 0, "R8");       // divisor 0 acts as 1
    send(9'h0C3, 6, 1, 0, 1, 5, 1, "R9");       // inputs churn mid-frame
    send(9'h11C, 8, 0, 0, 0, 1, 1, "R3");       // one-cycle bits with churn

    for (int n = 0; n < 150; n++) begin
      send(9'($urandom), int'($urandom_range(3, 12)), 1'($urandom), 1'($urandom),
           1'($urandom), int'($urandom_range(0, 6)), 1'($urandom), "R7");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule